// File: doc/BRIEF.md
# GPIO Port with Edge Capture

This block is a parallel I/O port behind a small 32-bit word-addressed register bus. Each pin has an output latch, an output-enable (direction) bit and an interrupt mask bit. Pin inputs pass through a two-flop synchronizer. The synchronized value can be read back and drives the interrupt logic.

The interrupt trigger is fixed per instance by the parameter `TRIG_MODE`. The choices are rising edge, falling edge, either edge, or active-high level, and all pins share the same choice. In the three edge modes, a detected edge on a pin sets that pin's bit in a capture register. Software clears capture bits by writing ones to them. In level mode the capture register is absent and the request follows the synchronized inputs directly. A single request line `irq` is the OR over all pins of the masked per-pin conditions.

Register map (byte offsets, decoded from `bus_addr[4:2]`):

| Offset | Function |
|---|---|
| 0x00 | Pin data: a read returns the synchronized inputs; a write loads the output latch |
| 0x04 | Output enable |
| 0x08 | Interrupt mask |
| 0x0C | Edge capture: writing 1 to a bit clears it |
| 0x10 | Set-bits port |
| 0x14 | Clear-bits port |

Writes take effect at the next rising clock edge. Read data is combinational from the register state while `bus_en=1` and `bus_we=0`, and is zero at all other times.

Top module: `gpio_edge_top`

## Requirements
- R1: After reset, every register is zero. `pin_out`, `pin_oe` and `irq` are 0, and a read of any offset returns 0.
- R2: A read of offset 0x00 returns `pin_in` as it was two rising edges earlier (two-stage synchronizer). Bits at or above `PIN_COUNT` read as 0 at every offset.
- R3: Offsets 0x04 and 0x08 are read/write registers holding output enable and mask. `pin_oe` equals the enable register, and a 1 in it drives the pin. A write to 0x00 loads `pin_out` with the written bits.
- R4: A write to 0x10 ORs the written ones into the output latch. A write to 0x14 clears the latch bits where ones are written. Bits written as 0 keep their value in both cases. Both offsets read as 0.
- R5: With `TRIG_MODE=TRIG_RISE`, a 0-to-1 change of a synchronized input sets its capture bit one edge after the change appears at offset 0x00.
- R6: With `TRIG_MODE=TRIG_FALL`, only 1-to-0 changes set capture bits.
- R7: With `TRIG_MODE=TRIG_BOTH`, any change sets the capture bit.
- R8: Writing 1 to a capture bit clears it. Writing 0 to a capture bit leaves it unchanged. Capture bits latch regardless of the mask.
- R9: If an edge is detected in the same cycle as a write-one-to-clear of its bit, the bit ends up set.
- R10: In the edge modes, `irq` is the OR of capture AND mask. With `TRIG_MODE=TRIG_LEVEL`, `irq` is the OR of synchronized input AND mask, and offset 0x0C reads 0.
- R11: Offsets 0x18 and 0x1C read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits [4:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | PIN_COUNT | Asynchronous pin inputs |
| pin_out | output | PIN_COUNT | Output latch value |
| pin_oe | output | PIN_COUNT | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench runs four instances side by side: one in each trigger mode, two of them narrower than 32 pins. Every cycle it compares all four against a cycle-accurate reference model.

Directed cases target the points most likely to be wrong:
- **Clear colliding with an edge.** A design that lets the clear win would silently drop an event.
- **Falling-edge and either-edge detection.** A design that uses the raw input, or samples one cycle early, would capture at the wrong time or miss a polarity.
- **Upper bits and unmapped offsets.** A narrow port that leaks the write bus onto the upper read bits, or decodes offsets 0x18 and 0x1C, would show nonzero data.
- **Level mode.** A design that kept capture state in level mode would hold the request after the pin falls.

// File: rtl/gpio_cap_pkg.sv
package gpio_cap_pkg;

    // Interrupt trigger chosen per instance at build time.
    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_e;

    // Word index taken from bus_addr[4:2]; the order fixes the offsets.
    typedef enum logic [2:0] {
        RG_DATA = 3'd0,
        RG_DIR  = 3'd1,
        RG_MASK = 3'd2,
        RG_CAP  = 3'd3,
        RG_SET  = 3'd4,
        RG_CLR  = 3'd5,
        RG_GAP6 = 3'd6,
        RG_GAP7 = 3'd7
    } reg_e;

    // One-hot write strobes produced by the address decoder.
    typedef struct packed {
        logic wr_data;
        logic wr_dir;
        logic wr_mask;
        logic wr_cap;
        logic wr_set;
        logic wr_clr;
    } wr_strobe_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

    // Two-edge latency from pin to synchronized value (R2).
    assert_sync_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (stage2_q == $past(async_in, 2)));

endmodule

// File: rtl/gpio_edge_cap.sv
module gpio_edge_cap
    import gpio_cap_pkg::*;
#(
    parameter int    W    = 32,
    parameter trig_e TRIG = TRIG_RISE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_in,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] cap_out
);

    if (TRIG == TRIG_LEVEL) begin : g_level
        // No capture storage in level mode; the register reads zero.
        logic unused_clr;
        logic unused_lvl;
        assign unused_clr = ^clr_bits;
        assign unused_lvl = ^level_in;
        assign cap_out    = '0;
    end else begin : g_edge
        logic [W-1:0] prev_q;
        logic [W-1:0] hit;
        logic [W-1:0] cap_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= '0;
            else        prev_q <= level_in;
        end

        always_comb begin
            unique case (TRIG)
                TRIG_RISE:  hit = level_in & ~prev_q;
                TRIG_FALL:  hit = ~level_in & prev_q;
                TRIG_BOTH:  hit = level_in ^ prev_q;
                TRIG_LEVEL: hit = '0;
            endcase
        end

        // A fresh edge overrides a simultaneous clear request (R9).
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cap_q <= '0;
            else        cap_q <= (cap_q & ~clr_bits) | hit;
        end

        assign cap_out = cap_q;

        assert_edge_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (hit != '0) |=> ((cap_q & $past(hit)) == $past(hit)));

        assert_clear_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_bits == '0) |=> ((cap_q & $past(cap_q)) == $past(cap_q)));

        assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $stable(level_in) |=> ((cap_q & ~$past(cap_q)) == '0));
    end

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_cap_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  wr_strobe_t   stb,
    input  logic [W-1:0] wd,
    output logic [W-1:0] out_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] mask_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (stb.wr_data) begin
            out_q <= wd;
        end else if (stb.wr_set) begin
            out_q <= out_q | wd;
        end else if (stb.wr_clr) begin
            out_q <= out_q & ~wd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          dir_q <= '0;
        else if (stb.wr_dir) dir_q <= wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           mask_q <= '0;
        else if (stb.wr_mask) mask_q <= wd;
    end

    assert_set_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stb.wr_set |=> (((out_q & $past(wd)) == $past(wd)) &&
                        ((out_q & ~$past(wd)) == ($past(out_q) & ~$past(wd)))));

    assert_clr_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stb.wr_clr |=> (((out_q & $past(wd)) == '0) &&
                        ((out_q & ~$past(wd)) == ($past(out_q) & ~$past(wd)))));

    assert_dir_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !stb.wr_dir |=> $stable(dir_q));

endmodule

// File: rtl/gpio_edge_top.sv
module gpio_edge_top
    import gpio_cap_pkg::*;
#(
    parameter int    PIN_COUNT = 32,
    parameter trig_e TRIG_MODE = TRIG_RISE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [4:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic                 irq
);

    localparam int W       = PIN_COUNT;
    localparam int IDX_LSB = 2;
    localparam int IDX_MSB = 4;

    reg_e         sel;
    wr_strobe_t   stb;
    logic [W-1:0] wr_bits;
    logic [W-1:0] sync_v;
    logic [W-1:0] cap_v;
    logic [W-1:0] out_v;
    logic [W-1:0] dir_v;
    logic [W-1:0] mask_v;
    logic [W-1:0] clr_v;
    logic [W-1:0] rd_w;
    logic         unused_lsb;

    assign sel        = reg_e'(bus_addr[IDX_MSB:IDX_LSB]);
    assign wr_bits    = bus_wdata[W-1:0];
    assign unused_lsb = ^bus_addr[IDX_LSB-1:0];

    // Address decode into one-hot write strobes.
    always_comb begin
        stb = '0;
        if (bus_en && bus_we) begin
            unique case (sel)
                RG_DATA: stb.wr_data = 1'b1;
                RG_DIR:  stb.wr_dir  = 1'b1;
                RG_MASK: stb.wr_mask = 1'b1;
                RG_CAP:  stb.wr_cap  = 1'b1;
                RG_SET:  stb.wr_set  = 1'b1;
                RG_CLR:  stb.wr_clr  = 1'b1;
                RG_GAP6, RG_GAP7: stb = '0;
            endcase
        end
    end

    assign clr_v = stb.wr_cap ? wr_bits : '0;

    gpio_sync #(.W(W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_v)
    );

    gpio_edge_cap #(.W(W), .TRIG(TRIG_MODE)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (sync_v),
        .clr_bits (clr_v),
        .cap_out  (cap_v)
    );

    gpio_regs #(.W(W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (stb),
        .wd     (wr_bits),
        .out_q  (out_v),
        .dir_q  (dir_v),
        .mask_q (mask_v)
    );

    assign pin_out = out_v;
    assign pin_oe  = dir_v;

    // Read multiplexer; set/clear ports and gaps return zero.
    always_comb begin
        rd_w = '0;
        if (bus_en && !bus_we) begin
            unique case (sel)
                RG_DATA: rd_w = sync_v;
                RG_DIR:  rd_w = dir_v;
                RG_MASK: rd_w = mask_v;
                RG_CAP:  rd_w = cap_v;
                RG_SET, RG_CLR, RG_GAP6, RG_GAP7: rd_w = '0;
            endcase
        end
    end

    if (W < 32) begin : g_narrow
        logic unused_hi;
        assign unused_hi = ^bus_wdata[31:W];
        assign bus_rdata = {{(32-W){1'b0}}, rd_w};
    end else begin : g_full
        assign bus_rdata = rd_w;
    end

    if (TRIG_MODE == TRIG_LEVEL) begin : g_irq_level
        assign irq = |(sync_v & mask_v);
    end else begin : g_irq_edge
        assign irq = |(cap_v & mask_v);
    end

    assert_irq_needs_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_v != '0));

    assert_gap_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr[4:3] == 2'b11) |-> (bus_rdata == '0));

    assert_gap_write_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr[4:3] == 2'b11) |=>
            ($stable(out_v) && $stable(dir_v) && $stable(mask_v)));

endmodule

// File: tb/gpio_edge_top_tb.sv
module gpio_edge_top_tb;
    import gpio_cap_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] pin_drv = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0] rd_a, rd_b, rd_c, rd_d;
    logic [31:0] po_a, oe_a, po_c, oe_c;
    logic [7:0]  po_b, oe_b, po_d, oe_d;
    logic        irq_a, irq_b, irq_c, irq_d;

    gpio_edge_top #(.PIN_COUNT(32), .TRIG_MODE(TRIG_RISE)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_a), .pin_in(pin_drv), .pin_out(po_a),
        .pin_oe(oe_a), .irq(irq_a));

    gpio_edge_top #(.PIN_COUNT(8), .TRIG_MODE(TRIG_FALL)) u_dut_fall (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_b), .pin_in(pin_drv[7:0]), .pin_out(po_b),
        .pin_oe(oe_b), .irq(irq_b));

    gpio_edge_top #(.PIN_COUNT(32), .TRIG_MODE(TRIG_BOTH)) u_dut_both (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_c), .pin_in(pin_drv), .pin_out(po_c),
        .pin_oe(oe_c), .irq(irq_c));

    gpio_edge_top #(.PIN_COUNT(8), .TRIG_MODE(TRIG_LEVEL)) u_dut_lvl (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_d), .pin_in(pin_drv[7:0]), .pin_out(po_d),
        .pin_oe(oe_d), .irq(irq_d));

    logic [31:0] act_rd[4];
    logic [31:0] act_po[4];
    logic [31:0] act_oe[4];
    logic        act_irq[4];

    always_comb begin
        act_rd[0] = rd_a; act_rd[1] = rd_b; act_rd[2] = rd_c; act_rd[3] = rd_d;
        act_po[0] = po_a; act_po[1] = {24'h0, po_b}; act_po[2] = po_c; act_po[3] = {24'h0, po_d};
        act_oe[0] = oe_a; act_oe[1] = {24'h0, oe_b}; act_oe[2] = oe_c; act_oe[3] = {24'h0, oe_d};
        act_irq[0] = irq_a; act_irq[1] = irq_b; act_irq[2] = irq_c; act_irq[3] = irq_d;
    end

    // Reference model state; index 0 rise/32, 1 fall/8, 2 both/32, 3 level/8.
    logic [31:0] m_s1[4], m_s2[4], m_prev[4], m_cap[4], m_out[4], m_dir[4], m_mask[4];

    function automatic logic [31:0] wmask(input int k);
        return (k == 1 || k == 3) ? 32'h0000_00FF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] edge_of(input int k, input logic [31:0] s, input logic [31:0] p);
        case (k)
            0:       return s & ~p;
            1:       return ~s & p;
            2:       return s ^ p;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(input int k, input logic en, input logic we, input logic [4:0] a);
        if (!en || we) return 32'h0;
        case (a[4:2])
            3'd0:    return m_s2[k];
            3'd1:    return m_dir[k];
            3'd2:    return m_mask[k];
            3'd3:    return m_cap[k];
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_irq(input int k);
        if (k == 3) return |(m_s2[k] & m_mask[k]);
        return |(m_cap[k] & m_mask[k]);
    endfunction

    function automatic string rd_tag(input int k, input logic [4:0] a);
        case (a[4:2])
            3'd0:       return "R2";
            3'd1, 3'd2: return "R3";
            3'd3:       return (k == 0) ? "R5" : (k == 1) ? "R6" : (k == 2) ? "R7" : "R10";
            3'd4, 3'd5: return "R4";
            default:    return "R11";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 4; k++) begin
            m_s1[k] = 0; m_s2[k] = 0; m_prev[k] = 0; m_cap[k] = 0;
            m_out[k] = 0; m_dir[k] = 0; m_mask[k] = 0;
        end
    endtask

    task automatic model_edge(input logic en, input logic we, input logic [4:0] a,
                              input logic [31:0] wd, input logic [31:0] pins);
        for (int k = 0; k < 4; k++) begin
            logic [31:0] wm, e, clr, wv;
            wm  = wmask(k);
            wv  = wd & wm;
            e   = edge_of(k, m_s2[k], m_prev[k]) & wm;
            clr = (en && we && a[4:2] == 3'd3) ? wv : 32'h0;
            m_cap[k]  = (k == 3) ? 32'h0 : ((m_cap[k] & ~clr) | e);
            m_prev[k] = m_s2[k];
            m_s2[k]   = m_s1[k];
            m_s1[k]   = pins & wm;
            if (en && we) begin
                case (a[4:2])
                    3'd0: m_out[k] = wv;
                    3'd1: m_dir[k] = wv;
                    3'd2: m_mask[k] = wv;
                    3'd4: m_out[k] = m_out[k] | wv;
                    3'd5: m_out[k] = m_out[k] & ~wv;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic compare_all();
        for (int k = 0; k < 4; k++) begin
            chk(rd_tag(k, bus_addr), $sformatf("rdata dut%0d addr %h", k, bus_addr),
                act_rd[k], exp_rd(k, bus_en, bus_we, bus_addr));
            chk("R10", $sformatf("irq dut%0d", k), {31'h0, act_irq[k]}, {31'h0, exp_irq(k)});
            chk("R4", $sformatf("pin_out dut%0d", k), act_po[k], m_out[k]);
            chk("R3", $sformatf("pin_oe dut%0d", k), act_oe[k], m_dir[k]);
        end
    endtask

    task automatic step(input logic en, input logic we, input logic [4:0] a,
                        input logic [31:0] wd, input logic [31:0] pins);
        bus_en = en; bus_we = we; bus_addr = a; bus_wdata = wd; pin_drv = pins;
        @(posedge clk);
        model_edge(en, we, a, wd, pins);
        #2;
        compare_all();
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] pins;
        model_reset();
        repeat (3) @(posedge clk);
        #2;
        // R1: reset values at the ports
        for (int k = 0; k < 4; k++) begin
            chk("R1", "pin_out after reset", act_po[k], 32'h0);
            chk("R1", "pin_oe after reset", act_oe[k], 32'h0);
            chk("R1", "irq after reset", {31'h0, act_irq[k]}, 32'h0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        for (int r = 0; r < 8; r++) step(1, 0, 5'(r * 4), 0, 0);   // R1 reads zero

        // R3 / R4 directed: data, set, clear, readback of set/clear ports
        step(1, 1, 5'h00, 32'hA5A5_0F0F, 0);
        step(1, 1, 5'h10, 32'h0000_F0F0, 0);
        chk("R4", "set ORs into latch", po_a, 32'hA5A5_FFFF);
        step(1, 1, 5'h14, 32'hA500_000F, 0);
        chk("R4", "clear removes written ones", po_a, 32'h00A5_FFF0);
        step(1, 0, 5'h10, 0, 0);
        chk("R4", "set port reads zero", rd_a, 32'h0);
        step(1, 1, 5'h04, 32'hFFFF_FFFF, 0);
        chk("R2", "narrow oe upper bits zero", act_oe[1], 32'h0000_00FF);
        step(1, 1, 5'h08, 32'hFFFF_FFFF, 0);

        // R11: unmapped write then read
        step(1, 1, 5'h18, 32'h1234_5678, 0);
        step(1, 0, 5'h1C, 0, 0);
        chk("R11", "gap read", rd_a, 32'h0);

        // R5/R6/R7/R10: raise pin 0, wait, read capture
        step(1, 0, 5'h0C, 0, 32'h1);
        step(1, 0, 5'h0C, 0, 32'h1);
        step(1, 0, 5'h0C, 0, 32'h1);
        chk("R5", "rise captured", rd_a, 32'h1);
        chk("R6", "fall ignores rise", rd_b, 32'h0);
        chk("R7", "both sees rise", rd_c, 32'h1);
        chk("R10", "level capture reads zero", rd_d, 32'h0);
        chk("R10", "level irq follows pin", {31'h0, irq_d}, 32'h1);
        step(1, 1, 5'h0C, 32'h0000_0000, 32'h1);
        step(1, 0, 5'h0C, 0, 32'h1);
        chk("R8", "write zero keeps capture", rd_a, 32'h1);
        step(1, 1, 5'h0C, 32'hFFFF_FFFF, 32'h1);
        step(1, 0, 5'h0C, 0, 32'h1);
        chk("R8", "write one clears capture", rd_a, 32'h0);
        step(1, 0, 5'h0C, 0, 32'h0);
        step(1, 0, 5'h0C, 0, 32'h0);
        step(1, 0, 5'h0C, 0, 32'h0);
        chk("R6", "fall captured", rd_b, 32'h1);
        chk("R7", "both sees fall", rd_c, 32'h1);
        chk("R5", "rise ignores fall", rd_a, 32'h0);
        chk("R10", "level irq drops", {31'h0, irq_d}, 32'h0);
        step(1, 1, 5'h0C, 32'hFFFF_FFFF, 32'h0);

        // R9: edge detected in the same cycle as a clear of that bit
        step(1, 0, 5'h00, 0, 32'h2);
        step(1, 0, 5'h00, 0, 32'h2);
        step(1, 1, 5'h0C, 32'hFFFF_FFFF, 32'h2);
        step(1, 0, 5'h0C, 0, 32'h2);
        chk("R9", "edge beats clear rise", rd_a, 32'h2);
        chk("R9", "edge beats clear both", rd_c, 32'h2);

        // Constrained random phase against the model
        void'($urandom(32'h5EED_1234));
        pins = 32'h2;
        for (int n = 0; n < N_RAND; n++) begin
            logic [2:0] idx;
            pins ^= ($urandom & $urandom & $urandom);
            idx = 3'($urandom % 8);
            step(($urandom % 4) != 0, $urandom % 2, {idx, 2'($urandom % 4)}, $urandom, pins);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule